// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block collects fourteen event sources into one pending-request register, masks them with an enable register and presents a 3-bit priority level to a processor. A level of 0 means that nothing is pending. The enable register and the request register are each 16 bits wide. Each has a write address and a separate read address on a small register bus.

Writes never overwrite a register directly. Data bit 15 selects the mode. When it is 1, every other data bit that is 1 sets the matching register bit. When it is 0, every other data bit that is 1 clears the matching register bit. Data bits that are 0 leave their register bits unchanged.

Enable bit 14 is a master switch. The sources fall into six fixed levels. When several levels are pending, the highest level number is reported. A request bit stays set until software clears it, so the level keeps being asserted for as long as the source is pending and enabled.

Top module: `irq_level_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, both registers hold 0 and `irq_level` is 0.
- R2: A write with data bit 15 = 1 sets each register bit whose data bit (14..0) is 1 and leaves the other bits unchanged. For example, writing 0xC020 to address 0 makes the enable register read 0x4020.
- R3: A write with data bit 15 = 0 clears each register bit whose data bit (14..0) is 1 and leaves the other bits unchanged.
- R4: The addresses are: 0 writes the enable register, 1 writes the request register, 2 reads the enable register, 3 reads the request register. `rdata` is 0 when `rd_en` is low or when the address is 0 or 1. Bit 15 always reads 0 on both read addresses, and request bit 14 always reads 0. Writes to addresses 2 and 3 change nothing.
- R5: A high on `src_pulse[i]` during a clock edge sets request bit i.
- R6: If a source pulse and a software clear of the same request bit fall in the same cycle, the bit ends up set.
- R7: A request bit stays set until it is cleared by a write. While it stays set and enabled, `irq_level` stays at its level.
- R8: When enable bit 14 is 0, `irq_level` is 0 whatever the other enables and requests hold.
- R9: Each request bit belongs to a fixed level: bits 0–2 to level 1, bit 3 to level 2, bits 4–6 to level 3, bits 7–10 to level 4, bits 11–12 to level 5, and bit 13 to level 6.
- R10: When several levels have a bit that is both requested and enabled, `irq_level` shows the highest such level.
- R11: Software can raise an interrupt by setting a request bit through address 1. For example, writing 0x8004 there raises level 1 when bit 2 is enabled.
- R12: `irq_level` is a register. It shows the level computed from the register contents of the previous cycle, so it changes one clock after a register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data; bit 15 selects set or clear |
| rdata | output | 16 | Read data |
| src_pulse | input | 14 | Hardware source event pulses |
| irq_level | output | 3 | Highest active priority level, 0 = none |

## Verification
A hardware source event and a software write to the request register can fall in the same cycle. The conflict that matters is a clear-mode write that hits the very bit the source is raising. The bench provokes this by pulsing a source on the cycle in which it writes a clear mask covering that bit. It then checks that the bit reads back set and that the level it feeds appears one clock later. A reference model compares the level and the read data every cycle, so the same-cycle case is judged exactly as ordinary traffic is.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DW         = 16;
    localparam int NSRC       = 14;
    localparam int LVLW       = 3;
    localparam int NLVL       = 6;
    localparam int MODE_BIT   = 15;
    localparam int MASTER_BIT = 14;
    localparam logic [DW-1:0] EN_KEEP  = 16'h7FFF;
    localparam logic [DW-1:0] REQ_KEEP = 16'h3FFF;

    typedef enum logic [1:0] {
        A_EN_WR  = 2'd0,
        A_REQ_WR = 2'd1,
        A_EN_RD  = 2'd2,
        A_REQ_RD = 2'd3
    } addr_e;

    typedef struct packed {
        logic [DW-1:0]   en;
        logic [DW-1:0]   req;
        logic [LVLW-1:0] lvl;
    } state_t;

    function automatic int src_level(input int i);
        if (i < 3)       return 1;
        else if (i < 4)  return 2;
        else if (i < 7)  return 3;
        else if (i < 11) return 4;
        else if (i < 13) return 5;
        else             return 6;
    endfunction

    function automatic logic [NSRC-1:0] level_mask(input int lv);
        logic [NSRC-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++)
            if (src_level(i) == lv) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/irq_setclr_next.sv
module irq_setclr_next #(
    parameter int W = 16,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic [W-1:0] cur,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] nxt
);
    logic [W-1:0] sel;
    logic [W-1:0] after_wr;

    always_comb begin
        sel      = wdata & KEEP;
        after_wr = cur;
        if (wr) begin
            if (wdata[W-1]) after_wr = cur | sel;
            else            after_wr = cur & ~sel;
        end
        // hardware set applied last: a same-cycle clear never loses an event
        nxt = (after_wr | hw_set) & KEEP;
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] active,
    output logic [LVLW-1:0] level
);
    logic [NLVL:1] hit;

    for (genvar lv = 1; lv <= NLVL; lv++) begin : g_lvl
        localparam logic [NSRC-1:0] MASK = level_mask(lv);
        assign hit[lv] = |(active & MASK);
    end

    always_comb begin
        level = '0;
        for (int lv = 1; lv <= NLVL; lv++)
            if (hit[lv]) level = LVLW'(lv);
    end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NSRC-1:0] src_pulse,
    output logic [LVLW-1:0] irq_level
);
    state_t state_d, state_q;

    logic            wr_en_reg, wr_req_reg;
    logic [DW-1:0]   en_nxt, req_nxt;
    logic [DW-1:0]   hw_req;
    logic [LVLW-1:0] enc_lvl;

    assign wr_en_reg  = wr_en && (addr == A_EN_WR);
    assign wr_req_reg = wr_en && (addr == A_REQ_WR);
    assign hw_req     = {{(DW-NSRC){1'b0}}, src_pulse};

    irq_setclr_next #(.W(DW), .KEEP(EN_KEEP)) u_en_next (
        .cur(state_q.en), .wr(wr_en_reg), .wdata(wdata),
        .hw_set('0), .nxt(en_nxt)
    );

    irq_setclr_next #(.W(DW), .KEEP(REQ_KEEP)) u_req_next (
        .cur(state_q.req), .wr(wr_req_reg), .wdata(wdata),
        .hw_set(hw_req), .nxt(req_nxt)
    );

    irq_prio_enc u_enc (
        .active(state_q.req[NSRC-1:0] & state_q.en[NSRC-1:0]),
        .level (enc_lvl)
    );

    always_comb begin
        state_d     = state_q;
        state_d.en  = en_nxt;
        state_d.req = req_nxt;
        state_d.lvl = state_q.en[MASTER_BIT] ? enc_lvl : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_EN_RD:  rdata = state_q.en;
                A_REQ_RD: rdata = state_q.req;
                default:  rdata = '0;
            endcase
        end
    end

    assign irq_level = state_q.lvl;

    // ---------------- assertions ----------------
    logic [DW-1:0] sw_clr_bits;
    assign sw_clr_bits = (wr_en && addr == A_REQ_WR && !wdata[MODE_BIT]) ? wdata : '0;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q.en == '0 && state_q.req == '0 && irq_level == '0));

    assert_status_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_REQ_RD) |-> (rdata[15:14] == 2'b00));

    assert_hw_pulse_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((state_q.req[NSRC-1:0] & $past(src_pulse)) == $past(src_pulse)));

    assert_req_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.req != '0) |=>
        ((state_q.req & $past(state_q.req & ~sw_clr_bits)) == $past(state_q.req & ~sw_clr_bits)));

    assert_master_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> $past(state_q.en[MASTER_BIT]));

    assert_level_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level <= LVLW'(NLVL));
endmodule

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [13:0] src_pulse = '0;
    logic [2:0]  irq_level;

    int vectors = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    logic [15:0] en_m, req_m;
    int lvl_m;

    always #5 clk = ~clk;

    irq_level_ctrl dut (.*);

    function automatic int lvl_of(input int i);
        case (i)
            0, 1, 2:     return 1;
            3:           return 2;
            4, 5, 6:     return 3;
            7, 8, 9, 10: return 4;
            11, 12:      return 5;
            default:     return 6;
        endcase
    endfunction

    function automatic int model_level(input logic [15:0] e, input logic [15:0] r);
        int best = 0;
        if (!e[14]) return 0;
        for (int i = 0; i < 14; i++)
            if (e[i] && r[i] && lvl_of(i) > best) best = lvl_of(i);
        return best;
    endfunction

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_m <= 0; req_m <= 0; lvl_m <= 0;
        end else begin
            logic [15:0] e, r;
            e = en_m; r = req_m;
            if (wr_en && addr == 0) begin
                if (wdata[15]) e = e | wdata; else e = e & ~wdata;
            end
            if (wr_en && addr == 1) begin
                if (wdata[15]) r = r | wdata; else r = r & ~wdata;
            end
            r = r | {2'b00, src_pulse};
            e[15] = 0; r[15] = 0; r[14] = 0;
            lvl_m <= model_level(en_m, req_m);
            en_m  <= e;
            req_m <= r;
        end
    end

    function automatic logic [15:0] exp_rd();
        if (!rd_en) return 0;
        if (addr == 2) return en_m;
        if (addr == 3) return req_m;
        return 0;
    endfunction

    task automatic cyc(input bit w, input bit r, input logic [1:0] a,
                       input logic [15:0] d, input logic [13:0] s);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; src_pulse = s;
        #1;
        vectors++;
        if (irq_level !== 3'(lvl_m)) begin
            errors++;
            $display("FAIL %s level: actual %0d expected %0d", cur_req, irq_level, lvl_m);
        end
        if (rdata !== exp_rd()) begin
            errors++;
            $display("FAIL %s rdata: actual %h expected %h", cur_req, rdata, exp_rd());
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 1, 3, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 1, 2, 0, 0);
        idle(2);

        // R2: set mode on enable register, reads 0x4020
        cur_req = "R2";
        cyc(1, 0, 0, 16'hC020, 0);
        cyc(0, 1, 2, 0, 0);
        // R3: clear bit 5, others unchanged
        cur_req = "R3";
        cyc(1, 0, 0, 16'h0020, 0);
        cyc(0, 1, 2, 0, 0);

        // R4: bit 15 reads 0, req bit 14 reads 0, write-only addresses and read-address writes
        cur_req = "R4";
        cyc(1, 0, 0, 16'hFFFF, 0);
        cyc(0, 1, 2, 0, 0);
        cyc(1, 0, 1, 16'hC000, 0);
        cyc(0, 1, 3, 0, 0);
        cyc(1, 0, 2, 16'h0FFF, 0);
        cyc(1, 0, 3, 16'hBFFF, 0);
        cyc(0, 1, 2, 0, 0);
        cyc(0, 1, 3, 0, 0);
        cyc(0, 1, 0, 0, 0);
        cyc(0, 1, 1, 0, 0);
        cyc(0, 0, 2, 0, 0);

        // R5 / R12: source pulse on vertical blank slot -> level 3 two edges later
        cur_req = "R5";
        cyc(0, 1, 3, 0, 14'h0020);
        cur_req = "R12";
        idle(2);
        // R7: stays asserted
        cur_req = "R7";
        idle(5);
        cyc(1, 0, 1, 16'h0020, 0);
        idle(2);

        // R9: every bit alone maps to its level
        cur_req = "R9";
        for (int i = 0; i < 14; i++) begin
            cyc(0, 1, 3, 0, 14'(1) << i);
            idle(2);
            cyc(1, 0, 1, 16'(1) << i, 0);
            idle(1);
        end

        // R10: highest level wins, then falls back
        cur_req = "R10";
        cyc(0, 1, 3, 0, 14'h2001);
        idle(2);
        cyc(1, 0, 1, 16'h2000, 14'h0080);
        idle(2);
        cyc(1, 0, 1, 16'h0080, 0);
        idle(2);

        // R8: master enable gates everything
        cur_req = "R8";
        cyc(1, 0, 0, 16'h4000, 14'h1000);
        idle(3);
        cyc(1, 0, 0, 16'hC000, 0);
        idle(2);
        cyc(1, 0, 1, 16'h3FFF, 0);
        idle(2);

        // R11: software raise of bit 2
        cur_req = "R11";
        cyc(1, 0, 1, 16'h8004, 0);
        idle(3);
        cyc(1, 0, 1, 16'h0004, 0);
        idle(2);

        // R6: pulse and clear of same bit in the same cycle
        cur_req = "R6";
        cyc(1, 0, 1, 16'h0080, 14'h0080);
        cyc(0, 1, 3, 0, 0);
        idle(2);
        cyc(1, 0, 1, 16'h3FFF, 14'h0002);
        idle(3);

        // R1: reset mid-run
        cur_req = "R1";
        cyc(0, 1, 3, 0, 14'h3FFF);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 1, 2, 0, 0);
        idle(2);

        finish_run();
    end
endmodule